// File: doc/BRIEF.md
# ECC Chunk Status Accumulator

This block sits behind an ECC decoder and folds the per-chunk correction status bytes of one page into a page verdict. The decoder hands over one 8-bit status byte per chunk, in chunk order, with a valid strobe. Each byte falls into one of four classes:

- clean;
- erased;
- corrected, with the byte giving the number of flipped bits;
- failed, meaning the chunk could not be repaired.

Across the page the block keeps the largest per-chunk correction count, the sum of all corrected bits, the number of failed chunks and a sticky failure flag.

A one-cycle start pulse opens a page and clears the running state. A one-cycle done pulse closes the page. One cycle after the done pulse, the result registers show the page verdict and the result-valid flag is set. The results then hold steady until the next start pulse. Firmware or a page-level controller reads the worst-chunk output to judge wear, or the failure flag to reject the page.

Top module: `ecc_page_status`

## Requirements
- R1: After reset, res_valid_o, res_fail_o, res_worst_o, res_total_o and res_fails_o are all zero.
- R2: A status byte of 0x00 (clean chunk) changes neither the total, the failed-chunk count, the maximum nor the failure flag.
- R3: A status byte of 0xFF (erased chunk) is treated as clean and changes no count, maximum or flag.
- R4: A status byte from 1 to 40 adds its value to the running total and raises the running maximum when it exceeds it.
- R5: A status byte of 0xFE (uncorrectable) adds one to the failed-chunk count and sets the failure flag, without touching total or maximum.
- R6: A status byte from 41 to 0xFD also counts as an uncorrectable chunk, exactly as in R5.
- R7: A done pulse sets res_valid_o on the following cycle, with the results covering every byte accepted up to and including the done cycle.
- R8: res_worst_o carries the page maximum when no chunk failed and reads zero when res_fail_o is set.
- R9: A start pulse clears the running state and all result outputs on the next cycle. A byte or done pulse in the same cycle as start is dropped.
- R10: Once valid, the results stay unchanged until the next start, even when further bytes arrive.
- R11: The corrected-bit total saturates at 0xFFFF.
- R12: The failed-chunk count saturates at 0xFFFF.
- R13: A byte presented while stat_valid_i is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that opens a page |
| stat_valid_i | input | 1 | Qualifies stat_byte_i |
| stat_byte_i | input | 8 | Chunk status byte |
| done_i | input | 1 | One-cycle pulse that closes a page |
| res_valid_o | output | 1 | Page results are valid |
| res_fail_o | output | 1 | At least one chunk of the page failed |
| res_worst_o | output | 8 | Largest per-chunk corrected count, zero on failure |
| res_total_o | output | 16 | Sum of corrected bits, saturating |
| res_fails_o | output | 16 | Number of failed chunks, saturating |

## Verification
The assertions take for granted that start and done arrive as single-cycle pulses on known values, and that the status byte is known whenever its strobe is high. The stability check on the results relies on done not being pulsed again before the next start. The random pages keep to these conditions: they draw bytes from all five classes, with idle gaps that carry junk bytes under a low strobe. Separate directed cases then drive overlapping start, byte and done pulses, and long runs that push both counters into saturation.

// File: rtl/ecc_stat_pkg.sv
// Package: shared widths, limits and the chunk classification type
// for the ECC chunk status accumulator.
package ecc_stat_pkg;
    parameter int STAT_W_DEF = 8;
    parameter int CNT_W_DEF  = 16;
    parameter int LIMIT_DEF  = 40;

    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_ERASED = 2'd1,
        CLS_CORR   = 2'd2,
        CLS_FAIL   = 2'd3
    } chunk_cls_e;
endpackage

// File: rtl/ecc_stat_classify.sv
// Module: ecc_stat_classify
// Sorts one chunk status byte into clean, erased, corrected or failed,
// and passes the corrected-bit count on.
// Assumes: all-ones marks an erased chunk and all-ones minus one marks an
// uncorrectable chunk; LIMIT is below both of those codes.
module ecc_stat_classify
    import ecc_stat_pkg::*;
#(
    parameter int STAT_W = STAT_W_DEF,
    parameter int LIMIT  = LIMIT_DEF
) (
    input  logic [STAT_W-1:0] code_i,
    output chunk_cls_e        cls_o,
    output logic [STAT_W-1:0] bits_o
);
    localparam logic [STAT_W-1:0] CODE_ERASED = '1;
    localparam logic [STAT_W-1:0] CODE_UNCORR = CODE_ERASED - 1'b1;
    localparam logic [STAT_W-1:0] LIM         = LIMIT[STAT_W-1:0];

    // Purpose: decode the status byte into its class and its bit count.
    always_comb begin
        bits_o = '0;
        if (code_i == '0) begin
            cls_o = CLS_CLEAN;
        end else if (code_i == CODE_ERASED) begin
            cls_o = CLS_ERASED;
        end else if (code_i == CODE_UNCORR || code_i > LIM) begin
            cls_o = CLS_FAIL;
        end else begin
            cls_o  = CLS_CORR;
            bits_o = code_i;
        end
    end
endmodule

// File: rtl/ecc_stat_accum.sv
// Module: ecc_stat_accum
// Running page state: the maximum per-chunk count, the saturating total
// of corrected bits, the saturating failed-chunk count and a sticky
// failure flag. It also exposes the next-state values so that a
// snapshot can include the byte of the current cycle.
// Assumes: take_i is already qualified against clear_i by the parent.
module ecc_stat_accum
    import ecc_stat_pkg::*;
#(
    parameter int STAT_W = STAT_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int LIMIT  = LIMIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  chunk_cls_e        cls_i,
    input  logic [STAT_W-1:0] bits_i,
    output logic [STAT_W-1:0] max_nxt_o,
    output logic [CNT_W-1:0]  total_nxt_o,
    output logic [CNT_W-1:0]  fails_nxt_o,
    output logic              flag_nxt_o
);
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;
    localparam logic [STAT_W-1:0] LIM     = LIMIT[STAT_W-1:0];

    logic [STAT_W-1:0] max_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  fails_q;
    logic              flag_q;
    logic [CNT_W:0]    total_sum;

    assign total_sum = {1'b0, total_q} + {{(CNT_W + 1 - STAT_W){1'b0}}, bits_i};

    // Purpose: compute the state after folding in the current byte.
    always_comb begin
        max_nxt_o   = max_q;
        total_nxt_o = total_q;
        fails_nxt_o = fails_q;
        flag_nxt_o  = flag_q;
        if (take_i) begin
            unique case (cls_i)
                CLS_CORR: begin
                    total_nxt_o = total_sum[CNT_W] ? CNT_MAX : total_sum[CNT_W-1:0];
                    if (bits_i > max_q) max_nxt_o = bits_i;
                end
                CLS_FAIL: begin
                    if (fails_q != CNT_MAX) fails_nxt_o = fails_q + 1'b1;
                    flag_nxt_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Purpose: hold the running state, cleared by reset or page start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            max_q   <= '0;
            total_q <= '0;
            fails_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            max_q   <= max_nxt_o;
            total_q <= total_nxt_o;
            fails_q <= fails_nxt_o;
            flag_q  <= flag_nxt_o;
        end
    end

    p_total_no_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> total_q >= $past(total_q));
    p_max_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        max_q <= LIM);
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clear_i) |=> flag_q);
    p_flag_matches_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fails_q != '0) == flag_q);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (total_q == '0 && fails_q == '0 && max_q == '0 && !flag_q));
endmodule

// File: rtl/ecc_stat_result.sv
// Module: ecc_stat_result
// Page result registers: they capture the running state on done, hold it
// until the next start, and force the worst-chunk field to zero on failure.
// Assumes: start has priority over done in the same cycle.
module ecc_stat_result #(
    parameter int STAT_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              done_i,
    input  logic [STAT_W-1:0] max_i,
    input  logic [CNT_W-1:0]  total_i,
    input  logic [CNT_W-1:0]  fails_i,
    input  logic              flag_i,
    output logic              valid_o,
    output logic              fail_o,
    output logic [STAT_W-1:0] worst_o,
    output logic [CNT_W-1:0]  total_o,
    output logic [CNT_W-1:0]  fails_o
);
    // Purpose: clear on start, snapshot on done, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            valid_o <= 1'b0;
            fail_o  <= 1'b0;
            worst_o <= '0;
            total_o <= '0;
            fails_o <= '0;
        end else if (done_i) begin
            valid_o <= 1'b1;
            fail_o  <= flag_i;
            worst_o <= flag_i ? '0 : max_i;
            total_o <= total_i;
            fails_o <= fails_i;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !start_i && !done_i) |=>
            ($stable(fail_o) && $stable(worst_o) && $stable(total_o) && $stable(fails_o)));
    p_fail_worst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> worst_o == '0);
    p_done_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i) |=> valid_o);
endmodule

// File: rtl/ecc_page_status.sv
// Module: ecc_page_status (top)
// Folds per-chunk ECC status bytes into a page verdict. A byte is taken
// when stat_valid_i is high and start_i is low.
// Assumes: start_i and done_i are single-cycle pulses.
module ecc_page_status
    import ecc_stat_pkg::*;
#(
    parameter int STAT_W = STAT_W_DEF,
    parameter int CNT_W  = CNT_W_DEF,
    parameter int LIMIT  = LIMIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stat_valid_i,
    input  logic [STAT_W-1:0] stat_byte_i,
    input  logic              done_i,
    output logic              res_valid_o,
    output logic              res_fail_o,
    output logic [STAT_W-1:0] res_worst_o,
    output logic [CNT_W-1:0]  res_total_o,
    output logic [CNT_W-1:0]  res_fails_o
);
    chunk_cls_e        cls;
    logic [STAT_W-1:0] bits;
    logic              take;
    logic [STAT_W-1:0] max_nxt;
    logic [CNT_W-1:0]  total_nxt;
    logic [CNT_W-1:0]  fails_nxt;
    logic              flag_nxt;

    assign take = stat_valid_i && !start_i;

    ecc_stat_classify #(.STAT_W(STAT_W), .LIMIT(LIMIT)) u_cls (
        .code_i (stat_byte_i),
        .cls_o  (cls),
        .bits_o (bits)
    );

    ecc_stat_accum #(.STAT_W(STAT_W), .CNT_W(CNT_W), .LIMIT(LIMIT)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_i),
        .take_i      (take),
        .cls_i       (cls),
        .bits_i      (bits),
        .max_nxt_o   (max_nxt),
        .total_nxt_o (total_nxt),
        .fails_nxt_o (fails_nxt),
        .flag_nxt_o  (flag_nxt)
    );

    ecc_stat_result #(.STAT_W(STAT_W), .CNT_W(CNT_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .done_i  (done_i),
        .max_i   (max_nxt),
        .total_i (total_nxt),
        .fails_i (fails_nxt),
        .flag_i  (flag_nxt),
        .valid_o (res_valid_o),
        .fail_o  (res_fail_o),
        .worst_o (res_worst_o),
        .total_o (res_total_o),
        .fails_o (res_fails_o)
    );
endmodule

// File: tb/tb_ecc_page_status.sv
module tb_ecc_page_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        stat_valid_i = 1'b0;
    logic [7:0]  stat_byte_i = 8'h00;
    logic        done_i = 1'b0;
    logic        res_valid_o;
    logic        res_fail_o;
    logic [7:0]  res_worst_o;
    logic [15:0] res_total_o;
    logic [15:0] res_fails_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int cyc = 0;

    // model of the running page state
    int m_max, m_total, m_fails;
    bit m_flag;

    always #10 clk = ~clk;   // 50 MHz

    ecc_page_status dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .stat_valid_i(stat_valid_i), .stat_byte_i(stat_byte_i), .done_i(done_i),
        .res_valid_o(res_valid_o), .res_fail_o(res_fail_o), .res_worst_o(res_worst_o),
        .res_total_o(res_total_o), .res_fails_o(res_fails_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // 0 clean, 1 erased, 2 corrected, 3 failed
    function automatic int cls_of(int b);
        if (b == 0) return 0;
        if (b == 255) return 1;
        if (b == 254 || b > 40) return 3;
        return 2;
    endfunction

    function automatic void model_take(int b);
        case (cls_of(b))
            2: begin
                m_total = (m_total + b > 65535) ? 65535 : m_total + b;
                if (b > m_max) m_max = b;
            end
            3: begin
                if (m_fails < 65535) m_fails++;
                m_flag = 1'b1;
            end
            default: ;
        endcase
    endfunction

    function automatic void model_clear();
        m_max = 0; m_total = 0; m_fails = 0; m_flag = 1'b0;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start();
        start_i = 1'b1; tick(); start_i = 1'b0;
        model_clear();
    endtask

    task automatic send(int b);
        stat_valid_i = 1'b1; stat_byte_i = b[7:0]; tick();
        stat_valid_i = 1'b0;
        model_take(b);
    endtask

    task automatic idle_junk(int b);
        stat_valid_i = 1'b0; stat_byte_i = b[7:0]; tick();
    endtask

    task automatic do_done();
        done_i = 1'b1; tick(); done_i = 1'b0;
    endtask

    task automatic check_result(string req);
        chk(req, "valid", res_valid_o, 1);
        chk(req, "fail", res_fail_o, m_flag);
        chk("R8", "worst", res_worst_o, m_flag ? 0 : m_max);
        chk(req, "total", res_total_o, m_total);
        chk(req, "fails", res_fails_o, m_fails);
    endtask

    function automatic int rand_byte();
        int sel = $urandom_range(0, 9);
        case (sel)
            0: return 0;
            1: return 255;
            2: return 254;
            3: return $urandom_range(41, 253);
            default: return $urandom_range(1, 40);
        endcase
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        repeat (3) tick();
        // R1: reset state
        chk("R1", "valid", res_valid_o, 0);
        chk("R1", "fail", res_fail_o, 0);
        chk("R1", "worst", res_worst_o, 0);
        chk("R1", "total", res_total_o, 0);
        chk("R1", "fails", res_fails_o, 0);
        rst_n = 1'b1;
        tick();

        // R2, R3: clean and erased bytes leave everything at zero
        do_start();
        send(0); send(255); send(0); send(255);
        do_done();
        check_result("R2");
        chk("R3", "total", res_total_o, 0);

        // R4: corrected counts
        do_start();
        send(3); send(17); send(40); send(1); send(0);
        do_done();
        check_result("R4");
        chk("R4", "worst", res_worst_o, 40);
        chk("R4", "total", res_total_o, 61);

        // R5: 0xFE fails the page
        do_start();
        send(5); send(254); send(9);
        do_done();
        check_result("R5");
        chk("R5", "fails", res_fails_o, 1);

        // R6: 41 and 0xFD fail too
        do_start();
        send(41); send(253); send(12);
        do_done();
        check_result("R6");
        chk("R6", "fails", res_fails_o, 2);

        // R13: junk with strobe low ignored
        do_start();
        send(7);
        idle_junk(30); idle_junk(254); idle_junk(99);
        do_done();
        check_result("R13");
        chk("R13", "total", res_total_o, 7);

        // R7: byte in the same cycle as done is included
        do_start();
        send(4);
        stat_valid_i = 1'b1; stat_byte_i = 8'd22; done_i = 1'b1; tick();
        stat_valid_i = 1'b0; done_i = 1'b0; model_take(22);
        check_result("R7");
        chk("R7", "total", res_total_o, 26);

        // R10: later bytes do not disturb results
        send(254); send(30); idle_junk(0);
        chk("R10", "total", res_total_o, 26);
        chk("R10", "fail", res_fail_o, 0);
        chk("R10", "worst", res_worst_o, 22);

        // R9: start clears outputs; byte and done with start dropped
        start_i = 1'b1; stat_valid_i = 1'b1; stat_byte_i = 8'd10; done_i = 1'b1; tick();
        start_i = 1'b0; stat_valid_i = 1'b0; done_i = 1'b0; model_clear();
        chk("R9", "valid", res_valid_o, 0);
        chk("R9", "total", res_total_o, 0);
        do_done();
        check_result("R9");
        chk("R9", "total_after", res_total_o, 0);

        // random pages
        for (int p = 0; p < 40; p++) begin
            do_start();
            for (int k = 0; k < $urandom_range(1, 12); k++) begin
                if ($urandom_range(0, 3) == 0) idle_junk($urandom_range(0, 255));
                send(rand_byte());
            end
            do_done();
            check_result("R4");
        end

        // R11: total saturation
        do_start();
        for (int k = 0; k < 1700; k++) send(40);
        do_done();
        check_result("R11");
        chk("R11", "total", res_total_o, 65535);

        // R12: failed-chunk count saturation
        do_start();
        for (int k = 0; k < 65540; k++) send(254);
        do_done();
        check_result("R12");
        chk("R12", "fails", res_fails_o, 65535);

        summary();
    end
endmodule